// File: doc/BRIEF.md
# Constant-Off-Time Current Limiter

This block is the digital regulation core for one H-bridge. On every clock it receives an unsigned code for the load current, a flag that says whether the code comes from the high-side or the low-side sense path, a strobe that marks each output transition, and two temperature flags. It drives a single tri-state request into the bridge control. It also emits a one-cycle pulse whenever it detects a short circuit.

When the current code reaches the active limit threshold, the bridge is released to high impedance for a fixed number of clock cycles. After that the request drops by itself and switching resumes. Each output transition opens a blanking window, and so do the end of an off period and the release of a latched fault. During that window the limit comparison is masked, but the short-circuit comparison keeps running. A short circuit or the shutdown temperature flag latches the bridge off until the re-arm input is raised with no fault present. The foldback temperature flag selects a lower limit threshold.

Top module: `cot_current_limiter`

## Requirements
- R1: When `cur_sample >= limit` while no blanking window is open, no off period is running, no fault is latched and `out_edge` is low, `bridge_off` goes high on the next cycle. It stays high for exactly OFF_CYC cycles and then drops without any outside action.
- R2: A blanking window of BLANK_CYC cycles opens on a cycle with `out_edge` high, at the end of an off period, and when a latched fault is released. While the window is open, and in the `out_edge` cycle itself, a sample at or above the limit starts no off period.
- R3: A short circuit is `cur_sample > SC_HS` when `sense_low` is 0 (high-side path) or `cur_sample > SC_LS` when `sense_low` is 1 (low-side path). It is checked on every cycle, including during blanking and off periods. It gives `short_pulse` high for one cycle on the next cycle and latches `bridge_off` high.
- R4: The limit is LIM_NOM when `temp_fold` is 0 and LIM_FOLD when `temp_fold` is 1.
- R5: `temp_shut` high latches `bridge_off` high from the next cycle without raising `short_pulse`.
- R6: A latched fault holds `bridge_off` high until a cycle with `rearm` high and no short circuit and no `temp_shut`. A `rearm` raised while a fault is still present keeps the latch set.
- R7: A limit event during an off period is ignored, and an `out_edge` during an off period does not lengthen it.
- R8: After reset `bridge_off` and `short_pulse` are both low.
- R9: A short circuit seen while a fault is already latched raises no further `short_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_sample | input | SAMPLE_W | Unsigned load-current code |
| sense_low | input | 1 | 1: sample is from the low-side path, 0: high-side path |
| out_edge | input | 1 | Strobe marking an output transition |
| temp_fold | input | 1 | Junction above the foldback temperature |
| temp_shut | input | 1 | Junction above the shutdown temperature |
| rearm | input | 1 | Clears a latched fault when no fault is present |
| bridge_off | output | 1 | Request to put the bridge outputs in high impedance |
| short_pulse | output | 1 | One-cycle short-circuit fault pulse |

## Verification
The assertions check on every cycle the following. An off period never outlasts OFF_CYC cycles unless a fault is latched. An unlatched rise of the request never comes sooner than BLANK_CYC cycles after a transition, an off-period end or a fault release. A short on either sense path always produces its pulse and the latch. The shutdown flag always forces the bridge off. Which threshold foldback selects can only be shown by the bench's scenarios. The same holds for the exact refusal of a `rearm` while a fault persists, and for the absence of a second pulse during a latched short. There, the behavioural model and the explicit counts of high and low cycles pin the values down.

// File: rtl/cotl_pkg.sv
package cotl_pkg;
  // Converts a duration in nanoseconds to whole clock cycles.
  function automatic int ns_to_cycles(input int clk_hz, input int dur_ns);
    return ((clk_hz / 1000) * dur_ns) / 1000000;
  endfunction
endpackage

// File: rtl/cotl_thresh.sv
module cotl_thresh #(
  parameter int SAMPLE_W = 11,
  parameter int LIM_NOM  = 650,
  parameter int LIM_FOLD = 420,
  parameter int SC_HS    = 1100,
  parameter int SC_LS    = 900
) (
  input  logic [SAMPLE_W-1:0] sample,
  input  logic                sense_low,
  input  logic                fold,
  output logic                lim_hit,
  output logic                sc_hit
);
  localparam logic [SAMPLE_W-1:0] LimNomC  = SAMPLE_W'(LIM_NOM);
  localparam logic [SAMPLE_W-1:0] LimFoldC = SAMPLE_W'(LIM_FOLD);
  localparam logic [SAMPLE_W-1:0] ScHsC    = SAMPLE_W'(SC_HS);
  localparam logic [SAMPLE_W-1:0] ScLsC    = SAMPLE_W'(SC_LS);

  logic [SAMPLE_W-1:0] lim_sel;
  logic [SAMPLE_W-1:0] sc_sel;

  always_comb begin
    lim_sel = fold ? LimFoldC : LimNomC;
    sc_sel  = sense_low ? ScLsC : ScHsC;
    lim_hit = (sample >= lim_sel);
    sc_hit  = (sample > sc_sel);
  end
endmodule

// File: rtl/cotl_downcnt.sv
module cotl_downcnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = clr | load | (cnt_q != '0);
    if (clr)            cnt_d = '0;
    else if (load)      cnt_d = load_val;
    else if (cnt_q != '0) cnt_d = cnt_q - W'(1);
    else                cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/cotl_fault_latch.sv
module cotl_fault_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic sc_hit,
  input  logic hot_shut,
  input  logic rearm,
  output logic latch_q,
  output logic sc_pulse_q,
  output logic release_now,
  output logic fault_now
);
  logic latch_d;
  logic pulse_d;

  always_comb begin
    fault_now   = sc_hit | hot_shut;
    release_now = latch_q & rearm & ~fault_now;
    latch_d     = fault_now | (latch_q & ~rearm);
    pulse_d     = sc_hit & ~latch_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q    <= 1'b0;
      sc_pulse_q <= 1'b0;
    end else begin
      latch_q    <= latch_d;
      sc_pulse_q <= pulse_d;
    end
  end
endmodule

// File: rtl/cot_current_limiter.sv
module cot_current_limiter #(
  parameter int CLK_HZ    = 50000000,
  parameter int OFF_NS    = 20000,
  parameter int BLANK_NS  = 16500,
  parameter int OFF_CYC   = cotl_pkg::ns_to_cycles(CLK_HZ, OFF_NS),
  parameter int BLANK_CYC = cotl_pkg::ns_to_cycles(CLK_HZ, BLANK_NS),
  parameter int SAMPLE_W  = 11,
  parameter int LIM_NOM   = 650,
  parameter int LIM_FOLD  = 420,
  parameter int SC_HS     = 1100,
  parameter int SC_LS     = 900
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SAMPLE_W-1:0] cur_sample,
  input  logic                sense_low,
  input  logic                out_edge,
  input  logic                temp_fold,
  input  logic                temp_shut,
  input  logic                rearm,
  output logic                bridge_off,
  output logic                short_pulse
);
  localparam int OFF_W   = $clog2(OFF_CYC + 1);
  localparam int BLANK_W = $clog2(BLANK_CYC + 1);
  localparam logic [OFF_W-1:0]   OffLoadC   = OFF_W'(OFF_CYC);
  localparam logic [BLANK_W-1:0] BlankLoadC = BLANK_W'(BLANK_CYC);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_in_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_in_n = rst_sync_q[1];

  logic lim_hit, sc_hit;
  logic latch_q, release_now, fault_now;
  logic [OFF_W-1:0]   off_cnt;
  logic [BLANK_W-1:0] blank_cnt;
  logic off_busy, off_last, blanking;
  logic off_clr, off_load, off_end, blank_load;

  cotl_thresh #(
    .SAMPLE_W(SAMPLE_W), .LIM_NOM(LIM_NOM), .LIM_FOLD(LIM_FOLD),
    .SC_HS(SC_HS), .SC_LS(SC_LS)
  ) u_thresh (
    .sample(cur_sample), .sense_low(sense_low), .fold(temp_fold),
    .lim_hit(lim_hit), .sc_hit(sc_hit)
  );

  cotl_fault_latch u_latch (
    .clk(clk), .rst_n(rst_in_n), .sc_hit(sc_hit), .hot_shut(temp_shut),
    .rearm(rearm), .latch_q(latch_q), .sc_pulse_q(short_pulse),
    .release_now(release_now), .fault_now(fault_now)
  );

  always_comb begin
    off_busy   = (off_cnt != '0);
    off_last   = (off_cnt == OFF_W'(1));
    blanking   = (blank_cnt != '0);
    off_clr    = fault_now | latch_q;
    off_load   = lim_hit & ~blanking & ~out_edge & ~off_busy;
    off_end    = off_last & ~off_clr;
    blank_load = out_edge | off_end | release_now;
  end

  cotl_downcnt #(.W(OFF_W)) u_off (
    .clk(clk), .rst_n(rst_in_n), .clr(off_clr), .load(off_load),
    .load_val(OffLoadC), .cnt(off_cnt)
  );

  cotl_downcnt #(.W(BLANK_W)) u_blank (
    .clk(clk), .rst_n(rst_in_n), .clr(1'b0), .load(blank_load),
    .load_val(BlankLoadC), .cnt(blank_cnt)
  );

  assign bridge_off = latch_q | off_busy;
endmodule

module cot_current_limiter_chk #(
  parameter int OFF_CYC   = 4,
  parameter int BLANK_CYC = 4,
  parameter int SAMPLE_W  = 11,
  parameter int SC_HS     = 1100,
  parameter int SC_LS     = 900
) (
  input logic                clk,
  input logic                rst_n,
  input logic [SAMPLE_W-1:0] cur_sample,
  input logic                sense_low,
  input logic                out_edge,
  input logic                temp_shut,
  input logic                bridge_off,
  input logic                short_pulse,
  input logic                latch_q
);
  localparam logic [SAMPLE_W-1:0] ScHsC = SAMPLE_W'(SC_HS);
  localparam logic [SAMPLE_W-1:0] ScLsC = SAMPLE_W'(SC_LS);

  int run_cnt;
  int quiet_cnt;
  logic prev_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt   <= 0;
      quiet_cnt <= BLANK_CYC + 1;
      prev_off  <= 1'b0;
    end else begin
      prev_off <= bridge_off;
      run_cnt  <= (bridge_off && !latch_q) ? run_cnt + 1 : 0;
      if (out_edge)                  quiet_cnt <= 0;
      else if (prev_off && !bridge_off) quiet_cnt <= 1;
      else if (quiet_cnt <= BLANK_CYC) quiet_cnt <= quiet_cnt + 1;
    end
  end

  assert_off_bounded_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bridge_off && !latch_q) |-> (run_cnt < OFF_CYC));

  assert_blank_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bridge_off && !prev_off && !latch_q) |-> (quiet_cnt > BLANK_CYC));

  assert_hs_short_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!bridge_off && !sense_low && cur_sample > ScHsC) |=> (short_pulse && bridge_off));

  assert_ls_short_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!bridge_off && sense_low && cur_sample > ScLsC) |=> (short_pulse && bridge_off));

  assert_shut_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    temp_shut |=> bridge_off);

  assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    short_pulse |=> !short_pulse);
endmodule

bind cot_current_limiter cot_current_limiter_chk #(
  .OFF_CYC(OFF_CYC), .BLANK_CYC(BLANK_CYC), .SAMPLE_W(SAMPLE_W),
  .SC_HS(SC_HS), .SC_LS(SC_LS)
) u_chk (
  .clk(clk), .rst_n(rst_in_n), .cur_sample(cur_sample), .sense_low(sense_low),
  .out_edge(out_edge), .temp_shut(temp_shut), .bridge_off(bridge_off),
  .short_pulse(short_pulse), .latch_q(latch_q)
);

// File: tb/cot_current_limiter_tb.sv
`timescale 1ns/1ps
module cot_current_limiter_tb_top;
  localparam int OFFC = 12;
  localparam int BLKC = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [10:0] cur_sample = '0;
  logic sense_low = 1'b0, out_edge = 1'b0, temp_fold = 1'b0;
  logic temp_shut = 1'b0, rearm = 1'b0;
  logic bridge_off, short_pulse;

  int n_chk = 0, n_err = 0;
  string cur_req = "R8";
  bit done = 1'b0;
  bit cmp_en = 1'b0;

  always #2.5 clk = ~clk;

  cot_current_limiter #(.OFF_CYC(OFFC), .BLANK_CYC(BLKC)) dut_i (
    .clk(clk), .rst_n(rst_n), .cur_sample(cur_sample), .sense_low(sense_low),
    .out_edge(out_edge), .temp_fold(temp_fold), .temp_shut(temp_shut),
    .rearm(rearm), .bridge_off(bridge_off), .short_pulse(short_pulse)
  );

  // Behavioural reference model.
  int  m_off = 0, m_blank = 0;
  bit  m_lat = 0, m_pulse = 0;
  always @(posedge clk) begin
    int  s, thr;
    bit  shrt, flt, rel, fin;
    if (!rst_n) begin
      m_off = 0; m_blank = 0; m_lat = 0; m_pulse = 0;
    end else begin
      s    = int'(cur_sample);
      thr  = temp_fold ? 420 : 650;
      shrt = sense_low ? (s > 900) : (s > 1100);
      flt  = shrt || temp_shut;
      rel  = m_lat && rearm && !flt;
      fin  = (m_off == 1) && !(flt || m_lat);
      m_pulse = shrt && !m_lat;
      if (flt || m_lat)  m_off = 0;
      else if (m_off > 0) m_off = m_off - 1;
      else if (s >= thr && m_blank == 0 && !out_edge) m_off = OFFC;
      if (out_edge || fin || rel) m_blank = BLKC;
      else if (m_blank > 0)       m_blank = m_blank - 1;
      m_lat = flt || (m_lat && !rearm);
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en) begin
      chk(cur_req, "bridge_off vs model", int'(bridge_off), int'(m_lat || m_off > 0));
      chk(cur_req, "short_pulse vs model", int'(short_pulse), int'(m_pulse));
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
    end
  end

  initial begin
    int n;
    cyc(3);
    chk("R8", "bridge_off in reset", int'(bridge_off), 0);
    chk("R8", "short_pulse in reset", int'(short_pulse), 0);
    rst_n = 1'b1;
    cyc(5);
    chk("R8", "bridge_off after reset", int'(bridge_off), 0);
    cmp_en = 1'b1;

    // R1 and R7: off time length and gap, with limit held during the off time.
    cur_req = "R1";
    cur_sample = 11'd700;
    cyc(1);
    n = 0;
    while (bridge_off && n < 100) begin n++; cyc(1); end
    chk("R1", "off period length", n, OFFC);
    cur_req = "R2";
    n = 0;
    while (!bridge_off && n < 100) begin n++; cyc(1); end
    chk("R2", "low gap after off end", n, BLKC + 1);
    cur_req = "R7";
    out_edge = 1'b1; cyc(1); out_edge = 1'b0;
    n = 1;
    while (bridge_off && n < 100) begin n++; cyc(1); end
    chk("R7", "edge during off does not extend", n, OFFC);
    cur_sample = 11'd100;
    cyc(BLKC + 3);

    // R2: strobe opens a window that masks the limit.
    cur_req = "R2";
    out_edge = 1'b1; cur_sample = 11'd700; cyc(1); out_edge = 1'b0;
    cyc(BLKC - 1);
    chk("R2", "masked inside window", int'(bridge_off), 0);
    cyc(3);
    chk("R2", "limit acts after window", int'(bridge_off), 1);
    cur_sample = 11'd100; cyc(OFFC + BLKC + 2);

    // R4: foldback threshold.
    cur_req = "R4";
    cur_sample = 11'd500; cyc(2);
    chk("R4", "500 below nominal limit", int'(bridge_off), 0);
    temp_fold = 1'b1; cyc(1);
    chk("R4", "500 above folded limit", int'(bridge_off), 1);
    cur_sample = 11'd419; cyc(OFFC + BLKC + 3);
    chk("R4", "419 below folded limit", int'(bridge_off), 0);
    temp_fold = 1'b0; cur_sample = 11'd100; cyc(2);

    // R3: short detection on both paths, also inside blanking.
    cur_req = "R3";
    sense_low = 1'b0; cur_sample = 11'd950; cyc(1);
    chk("R3", "950 on high side is no short", int'(short_pulse), 0);
    cur_sample = 11'd100; cyc(OFFC + BLKC + 3);
    sense_low = 1'b1; cur_sample = 11'd950; cyc(1);
    chk("R3", "950 on low side pulses", int'(short_pulse), 1);
    cur_req = "R9";
    cyc(1);
    chk("R9", "no second pulse while latched", int'(short_pulse), 0);
    cur_req = "R6";
    rearm = 1'b1; cyc(1); rearm = 1'b0;
    chk("R6", "rearm refused during fault", int'(bridge_off), 1);
    cur_sample = 11'd0; cyc(2);
    rearm = 1'b1; cyc(1); rearm = 1'b0;
    chk("R6", "rearm releases latch", int'(bridge_off), 0);
    cur_req = "R3";
    sense_low = 1'b0; out_edge = 1'b1; cur_sample = 11'd1200; cyc(1); out_edge = 1'b0;
    chk("R3", "high-side short inside blanking", int'(short_pulse), 1);
    cur_sample = 11'd0; rearm = 1'b1; cyc(1); rearm = 1'b0; cyc(BLKC + 2);

    // R5: shutdown temperature latches without pulse.
    cur_req = "R5";
    temp_shut = 1'b1; cyc(1);
    chk("R5", "shutdown forces off", int'(bridge_off), 1);
    chk("R5", "shutdown gives no pulse", int'(short_pulse), 0);
    temp_shut = 1'b0; cyc(3);
    chk("R6", "latch held without rearm", int'(bridge_off), 1);
    rearm = 1'b1; cyc(1); rearm = 1'b0; cyc(BLKC + 2);
    chk("R6", "released after rearm", int'(bridge_off), 0);

    cmp_en = 1'b0;
    done = 1'b1;
    summary();
  end
endmodule